// File: doc/BRIEF.md
# Serial Gamma-Channel Code Register Bank

This block is the digital front end of a multi-channel reference voltage generator for display panels. A three-wire serial host drives a clock, a data line and an active-high enable. While the enable is high the block shifts in 16-bit command words. When the enable drops after exactly sixteen clock pulses, the word is applied. Its low ten bits are a converter code. The four bits above them pick one of twelve channel registers. The top two bits are control bits, and the lower of them selects the refresh clock source. The channel codes leave the block as parallel buses that feed the converter array.

All three serial inputs are synchronised to the local clock `clk_i`, and serial clock edges are detected in that domain. For this the serial clock must be several times slower than `clk_i`. A serial output carries the bits that arrived sixteen serial clocks earlier, so several devices can be chained on one enable line. The analog transfer, REFL + code/1024 x (REFH - REFL), is not part of the block. The bench models it only to check that the codes map onto the intended voltages.

Top module: `gspi_gamma_bank`

## Requirements
- R1: Data is sampled on the synchronised rising edge of `sclk_i` while `en_i` is high, most significant bit first. In the 16-bit word, bits [15:14] are control, bits [13:10] are the channel address and bits [9:0] are the code.
- R2: When `en_i` falls after exactly 16 rising edges, the code is written to channel `addr` (0 to 11). Channel i appears on `chan_code_o[i*10 +: 10]`.
- R3: A burst of any other length (for example 15 or 17 edges) changes neither a channel code nor the mode.
- R4: Address values 12 to 15 write no channel, but the mode bit of the word is still applied.
- R5: `ext_clk_sel_o` equals bit 14 of the last accepted word: 1 selects the external clock and 0 selects the internal oscillator.
- R6: While `rst_ni` is low and after reset, all channel codes are 0, `ext_clk_sel_o` is 0 (internal) and `sdo_o` is 0.
- R7: Before the k-th rising edge of a burst (k from 0), `sdo_o` shows the bit that was received 16 edges before that edge. In a chain, this is bit 15-k of the previous 16-bit word.
- R8: `sclk_i` edges while `en_i` is low change no state, including the data that `sdo_o` will shift out.
- R9: An accepted write changes only the addressed channel. All other channels keep their codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock used for sampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| en_i | input | 1 | Frame enable, active high |
| sdo_o | output | 1 | Serial data out, delayed by 16 edges, for chaining |
| ext_clk_sel_o | output | 1 | Refresh clock source: 1 external, 0 internal |
| chan_code_o | output | NUM_CH*10 | Packed channel codes, channel 0 in the low bits |

## Verification
The assertions check four things on every cycle:
- the output shift path advances by one bit per enabled edge;
- the shift state is frozen while the enable is low;
- a channel or mode changes only on an accepted word, and at most one channel is written;
- an out-of-range address leaves every channel untouched.

Only the bench scenarios can show the end-to-end results. These are the decoding of every address with computed codes, and the rejection of 15- and 17-edge bursts as seen at the outputs. The bench also compares the chained output bit by bit against a shift model, and converts the resulting codes into the ideal reference voltages.

// File: rtl/gspi_pkg.sv
package gspi_pkg;
  localparam int CTRL_W   = 2;
  localparam int ADDR_W   = 4;
  localparam int CODE_W   = 10;
  localparam int FRAME_W  = CTRL_W + ADDR_W + CODE_W;
  localparam int MODE_BIT = CODE_W + ADDR_W;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
  } frame_t;
endpackage

// File: rtl/gspi_sync.sv
module gspi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gspi_frame_rx.sv
module gspi_frame_rx
  import gspi_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sclk_i,
  input  logic   sdi_i,
  input  logic   en_i,
  output logic   sdo_o,
  output logic   commit_o,
  output frame_t frame_o
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic               sclk_q, en_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               rise, en_fall;

  assign rise    = sclk_i & ~sclk_q;
  assign en_fall = en_q & ~en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      en_q     <= 1'b0;
      shreg_q  <= '0;
      cnt_q    <= '0;
      commit_o <= 1'b0;
      frame_o  <= '0;
    end else begin
      sclk_q   <= sclk_i;
      en_q     <= en_i;
      if (rise && en_i) shreg_q <= {shreg_q[FRAME_W-2:0], sdi_i};
      if (!en_i)                               cnt_q <= '0;
      else if (rise && cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      // length judged on the count held before the enable dropped
      commit_o <= en_fall && (cnt_q == CNT_W'(FRAME_W));
      if (en_fall) frame_o <= frame_t'(shreg_q);
    end
  end

  assign sdo_o = shreg_q[FRAME_W-1];

  p_sdo_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && en_i) |=> (sdo_o == $past(shreg_q[FRAME_W-2])));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> $stable(shreg_q));

  p_commit_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> ($past(en_q) && !$past(en_i)));
endmodule

// File: rtl/gspi_chan_bank.sv
module gspi_chan_bank
  import gspi_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          commit_i,
  input  frame_t                        frame_i,
  output logic [NUM_CH-1:0][CODE_W-1:0] codes_o,
  output logic                          ext_sel_o
);
  logic [NUM_CH-1:0] wr_en;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign wr_en[i] = commit_i && (frame_i.addr == ADDR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       codes_o[i] <= '0;
      else if (wr_en[i]) codes_o[i] <= frame_i.code;
    end
  end

  // ctrl[0] is word bit MODE_BIT
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ext_sel_o <= 1'b0;
    else if (commit_i) ext_sel_o <= frame_i.ctrl[0];
  end

  p_single_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en));

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && frame_i.addr < ADDR_W'(NUM_CH))
      |=> (codes_o[$past(frame_i.addr)] == $past(frame_i.code)));

  p_bad_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && frame_i.addr >= ADDR_W'(NUM_CH)) |=> $stable(codes_o));

  p_no_commit_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i) |=> ($stable(codes_o) && $stable(ext_sel_o)));

  p_mode_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (ext_sel_o == $past(frame_i.ctrl[0])));
endmodule

// File: rtl/gspi_gamma_bank.sv
module gspi_gamma_bank
  import gspi_pkg::*;
#(
  parameter int NUM_CH      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     sdi_i,
  input  logic                     en_i,
  output logic                     sdo_o,
  output logic                     ext_clk_sel_o,
  output logic [NUM_CH*CODE_W-1:0] chan_code_o
);
  logic [2:0]                    sync_s;
  logic                          commit;
  frame_t                        frame;
  logic [NUM_CH-1:0][CODE_W-1:0] codes;

  gspi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_i, sdi_i, sclk_i}),
    .q_o   (sync_s)
  );

  gspi_frame_rx u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sync_s[0]),
    .sdi_i   (sync_s[1]),
    .en_i    (sync_s[2]),
    .sdo_o   (sdo_o),
    .commit_o(commit),
    .frame_o (frame)
  );

  gspi_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .frame_i  (frame),
    .codes_o  (codes),
    .ext_sel_o(ext_clk_sel_o)
  );

  assign chan_code_o = codes;

  p_reset_state_r6: assert property (@(posedge clk_i)
    (!rst_ni) |-> (chan_code_o == '0 && !ext_clk_sel_o && !sdo_o));
endmodule

// File: tb/tb_gspi_gamma_bank.sv
module tb_gspi_gamma_bank;
  localparam int NCH = 12;
  localparam int CW  = 10;

  logic clk = 1'b0, rst_ni = 1'b0, sclk = 1'b0, sdi = 1'b0, en = 1'b0;
  logic sdo, ext_sel;
  logic [NCH*CW-1:0] codes;

  int checks = 0, failures = 0;
  int exp_code [NCH];
  bit exp_mode = 1'b0;
  logic [15:0] sh_m = '0;
  int sdo_bad;

  always #5 clk = ~clk;

  gspi_gamma_bank #(.NUM_CH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdi_i(sdi), .en_i(en),
    .sdo_o(sdo), .ext_clk_sel_o(ext_sel), .chan_code_o(codes)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // n bits MSB first; sdo sampled before each rise against a shift model (R7)
  task automatic burst(input logic [31:0] bits, input int n);
    sdo_bad = 0;
    en = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      repeat (5) @(negedge clk);
      if (sdo !== sh_m[15]) sdo_bad++;
      sclk = 1'b1;
      sh_m = {sh_m[14:0], sdi};
      repeat (5) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    en = 1'b0;
    repeat (10) @(negedge clk);
    chk(sdo_bad == 0, "R7 sdo delayed stream", sdo_bad, 0);
  endtask

  task automatic send(input int ctrl, input int addr, input int code);
    burst(32'((ctrl << 14) | (addr << 10) | code), 16);
    exp_mode = ctrl[0];
    if (addr < NCH) exp_code[addr] = code;
  endtask

  task automatic check_all(input string req);
    int bad = 0;
    for (int c = 0; c < NCH; c++)
      if (int'(codes[c*CW +: CW]) != exp_code[c]) begin
        bad++;
        chk(1'b0, req, int'(codes[c*CW +: CW]), exp_code[c]);
      end
    if (bad == 0) chk(1'b1, req, 0, 0);
    chk(ext_sel == exp_mode, {req, " R5 mode"}, int'(ext_sel), int'(exp_mode));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    for (int c = 0; c < NCH; c++) exp_code[c] = 0;
    repeat (3) @(negedge clk);
    chk(codes == '0 && ext_sel == 1'b0 && sdo == 1'b0, "R6 in reset", int'(ext_sel), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R6 after reset");

    // R1 R2 R9 R4: sweep every address with computed codes and alternating mode
    for (int a = 0; a < 16; a++) begin
      send(a % 2, a, (a * 83 + 5) % 1024);
      check_all("R2 R9 sweep");
      if (a >= NCH) chk(ext_sel == a[0], "R4 mode applied on bad addr", int'(ext_sel), a % 2);
    end

    // R2 boundary codes
    send(0, 0, 1023);  check_all("R2 code 1023 ch0");
    send(1, 11, 0);    check_all("R2 code 0 ch11");
    send(2, 11, 1023); check_all("R2 ctrl1 ignored, mode 0");
    send(1, 2, 513);   check_all("R1 ch C 513");
    send(0, 7, 31);    check_all("R1 ch H 31");

    // R3: wrong lengths
    burst(32'((1 << 14) | (3 << 10) | 777), 15); check_all("R3 short burst");
    burst(32'(((1 << 14) | (4 << 10) | 555) << 1), 17); check_all("R3 long burst");

    // R8: serial clocks with enable low
    sdi = 1'b1;
    for (int i = 0; i < 8; i++) begin
      repeat (5) @(negedge clk); sclk = 1'b1;
      repeat (5) @(negedge clk); sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk(sdo === sh_m[15], "R8 sdo unchanged", int'(sdo), int'(sh_m[15]));
    check_all("R8 regs unchanged");
    send(1, 5, 600); check_all("R8 next word still aligned");
    send(0, 13, 1);  check_all("R4 addr 13");

    // R2: ideal analog transfer from codes
    for (int c = 0; c < NCH; c++) begin
      real v_act, v_exp;
      v_act = 2.0 + (real'(codes[c*CW +: CW]) / 1024.0) * (13.0 - 2.0);
      v_exp = 2.0 + (real'(exp_code[c]) / 1024.0) * (13.0 - 2.0);
      chk((v_act - v_exp) < 1.0e-9 && (v_exp - v_act) < 1.0e-9,
          "R2 ideal voltage", int'(v_act * 1000.0), int'(v_exp * 1000.0));
    end
    summary();
  end
endmodule